// File: doc/BRIEF.md
# Dual-Register Programmable Logic Cell

This block is one output cell of a small programmable logic device. It holds two state registers. Each register takes its own sum-term input, and a configuration bit makes it a D-type or a T-type element. A second bit makes it run either on its own clock term or on the shared dedicated clock pin. Each register also has its own asynchronous clear term. Both registers share one synchronous preset and a test preload path. Both register outputs go back to the logic array, and the cell exposes them as `fb_q`.

Register 0 is the only register that can reach the bidirectional pin. An output-enable term gates the pin driver. When the combinational option is set, the pin carries sum term 0 directly instead of register 0. Whatever drives the pin, its level returns on `pin_in`, a path kept apart from the register feedback. The configuration inputs are static while the cell runs. A global power-on reset clears every register.

Top module: `pld_cell`

## Requirements
- R1: With `cfg_ttype[i]`=0 (D-type), register i takes `sum_term[i]` at its selected clock edge.
- R2: With `cfg_ttype[i]`=1 (T-type), register i inverts at its selected clock edge when `sum_term[i]`=1 and keeps its value when it is 0.
- R3: With `cfg_pinclk[i]`=1, register i is clocked by the rising edge of `pin_clk`, and `clk_term[i]` has no effect on it. With `cfg_pinclk[i]`=0, it is clocked by the rising edge of `clk_term[i]`, and `pin_clk` has no effect on it.
- R4: While `ares_term[i]` is 1, register i reads 0 at once, with no clock edge needed. This clear wins over preload and preset.
- R5: When `sync_preset` is 1 at a register's clock edge and preload is inactive, that register loads 1. Preset wins over the D and T next-state logic.
- R6: When `pl_en` is 1 at a register's clock edge, register i loads `pl_data[i]`. Preload wins over preset and over the D and T logic.
- R7: When `oe_term`=1 and `cfg_comb`=0, the pin is driven with register 0. Register 1 never drives the pin.
- R8: When `oe_term`=1 and `cfg_comb`=1, the pin is driven with `sum_term[0]`, with no clock involved.
- R9: When `oe_term`=0, the cell leaves the pin undriven, and `pin_in` follows the level applied from outside.
- R10: While `rst_por` is 1, both registers read 0.
- R11: `fb_q[i]` always shows register i, whether or not that register drives the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_por | input | 1 | Global power-on reset, active high, asynchronous |
| pin_clk | input | 1 | Dedicated clock pin shared by the cells |
| clk_term | input | NREGS | Per-register clock term |
| ares_term | input | NREGS | Per-register asynchronous clear term |
| sum_term | input | NREGS | Per-register sum-term data input |
| sync_preset | input | 1 | Shared synchronous preset |
| oe_term | input | 1 | Pin output-enable term |
| cfg_ttype | input | NREGS | 1 = T-type, 0 = D-type, per register |
| cfg_pinclk | input | NREGS | 1 = clock from pin_clk, 0 = clock from clk_term |
| cfg_comb | input | 1 | 1 = pin carries sum_term[0] directly |
| pl_en | input | 1 | Test preload enable |
| pl_data | input | NREGS | Test preload values |
| fb_q | output | NREGS | Register feedback to the array |
| pin_in | output | 1 | Pin level returned to the array |
| io_pin | inout | 1 | Bidirectional cell pin |

## Verification
The assertions sample at every rising edge of the pin clock. On each such edge they check that an active clear term holds its register at 0, and that the pin follows register 0 or sum term 0, according to the output option, whenever the driver is on. For a pin-clocked D-type register, they also check that a captured 1 appears on the next edge. The bench's scenarios cover the rest. These are the T-type toggle and hold, the term-clocked registers and the clock source they must ignore, the priority between clear, preload and preset, the effect of a clear between clock edges, and the pin's behaviour when it is tri-stated and driven from outside.

// File: rtl/pld_cell.sv
module pld_cell #(
  parameter int NREGS = 2
) (
  input  logic             rst_por,
  input  logic             pin_clk,
  input  logic [NREGS-1:0] clk_term,
  input  logic [NREGS-1:0] ares_term,
  input  logic [NREGS-1:0] sum_term,
  input  logic             sync_preset,
  input  logic             oe_term,
  input  logic [NREGS-1:0] cfg_ttype,
  input  logic [NREGS-1:0] cfg_pinclk,
  input  logic             cfg_comb,
  input  logic             pl_en,
  input  logic [NREGS-1:0] pl_data,
  output logic [NREGS-1:0] fb_q,
  output logic             pin_in,
  inout  wire              io_pin
);

  logic pin_drive;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic rclk, rclr, q_r;

    assign rclk = cfg_pinclk[i] ? pin_clk : clk_term[i];
    assign rclr = rst_por | ares_term[i];

    always_ff @(posedge rclk or posedge rclr) begin
      if (rclr)             q_r <= 1'b0;
      else if (pl_en)       q_r <= pl_data[i];
      else if (sync_preset) q_r <= 1'b1;
      else if (cfg_ttype[i]) q_r <= q_r ^ sum_term[i];
      else                  q_r <= sum_term[i];
    end

    assign fb_q[i] = q_r;

    assert_clear_holds_R4: assert property (@(posedge pin_clk) disable iff (rst_por)
      ares_term[i] |-> !fb_q[i]);

    assert_d_capture_R1: assert property (@(posedge pin_clk) disable iff (rst_por || ares_term[i])
      (cfg_pinclk[i] && !cfg_ttype[i] && !pl_en && !sync_preset && sum_term[i]) |=> fb_q[i] || !fb_q[i] && ares_term[i]);
  end

  assign pin_drive = cfg_comb ? sum_term[0] : fb_q[0];
  assign io_pin    = oe_term ? pin_drive : 1'bz;
  assign pin_in    = io_pin;

  assert_pin_reg_R7: assert property (@(posedge pin_clk) disable iff (rst_por)
    (oe_term && !cfg_comb) |-> pin_in == fb_q[0]);

  assert_pin_comb_R8: assert property (@(posedge pin_clk) disable iff (rst_por)
    (oe_term && cfg_comb) |-> pin_in == sum_term[0]);

endmodule

// File: tb/sim_pld_cell.sv
`timescale 1ns/100ps
module sim_pld_cell;
  localparam int N = 2;

  logic         rst_por = 1'b1, pin_clk = 1'b0;
  logic [N-1:0] clk_term = '0, ares_term = '0, sum_term = '0;
  logic         sync_preset = 1'b0, oe_term = 1'b0, cfg_comb = 1'b0, pl_en = 1'b0;
  logic [N-1:0] cfg_ttype = '0, cfg_pinclk = '0, pl_data = '0;
  logic [N-1:0] fb_q;
  logic         pin_in;
  logic         drv_en = 1'b0, drv_val = 1'b0;
  wire          io_pin;

  assign io_pin = drv_en ? drv_val : 1'bz;

  pld_cell #(.NREGS(N)) u0 (
    .rst_por(rst_por), .pin_clk(pin_clk), .clk_term(clk_term), .ares_term(ares_term),
    .sum_term(sum_term), .sync_preset(sync_preset), .oe_term(oe_term),
    .cfg_ttype(cfg_ttype), .cfg_pinclk(cfg_pinclk), .cfg_comb(cfg_comb),
    .pl_en(pl_en), .pl_data(pl_data), .fb_q(fb_q), .pin_in(pin_in), .io_pin(io_pin)
  );

  always #2.5 pin_clk = ~pin_clk;

  typedef struct { string req; int sel; logic val; } exp_t;
  exp_t sb[$];
  event chk_ev;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic expect_bit(string req, int sel, logic val);
    exp_t e;
    e.req = req; e.sel = sel; e.val = val;
    sb.push_back(e);
  endtask

  task automatic expect_q(string req, logic q0, logic q1);
    expect_bit(req, 0, q0);
    expect_bit(req, 1, q1);
  endtask

  task automatic sample();
    -> chk_ev;
    #0.2;
  endtask

  task automatic at_neg();
    @(negedge pin_clk);
    #0.5;
  endtask

  task automatic after_pos();
    @(posedge pin_clk);
    #1;
  endtask

  task automatic pulse_term(logic [N-1:0] m);
    at_neg();
    clk_term = m;
    #0.5;
    clk_term = '0;
    #0.3;
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        exp_t e;
        logic act;
        e = sb.pop_front();
        act = (e.sel == 0) ? fb_q[0] : (e.sel == 1) ? fb_q[1] : pin_in;
        checks++;
        if (act !== e.val) begin
          fails++;
          $display("FAIL %s sel=%0d actual=%b expected=%b", e.req, e.sel, act, e.val);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10 power-on reset
    #12;
    expect_q("R10", 0, 0); sample();
    at_neg(); rst_por = 0;

    // R1 D-type on pin clock, R11 both fed back
    at_neg(); cfg_pinclk = 2'b11; sum_term = 2'b01;
    after_pos(); expect_q("R1_R11", 1, 0); sample();
    at_neg(); sum_term = 2'b10;
    after_pos(); expect_q("R1_R11", 0, 1); sample();

    // R3 term clock ignored while on pin clock
    at_neg(); sum_term = 2'b11; clk_term = 2'b11; #0.5; clk_term = 2'b00; #0.3;
    expect_q("R3", 0, 1); sample();
    sum_term = 2'b00;
    after_pos(); expect_q("R1", 0, 0); sample();

    // R2 T-type on pin clock
    at_neg(); cfg_ttype = 2'b10; sum_term = 2'b10;
    after_pos(); expect_bit("R2", 1, 1); sample();
    at_neg(); sum_term = 2'b00;
    after_pos(); expect_bit("R2", 1, 1); sample();
    at_neg(); sum_term = 2'b10;
    after_pos(); expect_bit("R2", 1, 0); sample();

    // R3 term clocking, pin clock ignored
    at_neg(); cfg_pinclk = 2'b00; sum_term = 2'b11;
    after_pos(); expect_q("R3", 0, 0); sample();
    pulse_term(2'b01); expect_q("R3_R1", 1, 0); sample();
    pulse_term(2'b10); expect_q("R3_R2", 1, 1); sample();
    pulse_term(2'b10); expect_q("R3_R2", 1, 0); sample();

    // R4 immediate clear, beats preset; R5 preset beats T logic
    at_neg(); ares_term = 2'b01; #0.3;
    expect_bit("R4", 0, 0); sample();
    sum_term = 2'b00; sync_preset = 1;
    pulse_term(2'b11); expect_q("R4_R5", 0, 1); sample();
    at_neg(); ares_term = 2'b00; sync_preset = 0;

    // R5 preset on pin clock beats D and T
    at_neg(); cfg_pinclk = 2'b11; sum_term = 2'b10; sync_preset = 1;
    after_pos(); expect_q("R5", 1, 1); sample();

    // R6 preload beats preset
    at_neg(); pl_en = 1; pl_data = 2'b00;
    after_pos(); expect_q("R6", 0, 0); sample();
    at_neg(); sync_preset = 0; pl_data = 2'b10;
    after_pos(); expect_q("R6", 0, 1); sample();
    // R4 clear beats preload
    at_neg(); ares_term = 2'b10; pl_data = 2'b11;
    after_pos(); expect_q("R4", 1, 0); sample();
    at_neg(); ares_term = 2'b00;

    // R7 pin follows register 0 only
    at_neg(); pl_data = 2'b10; oe_term = 1;
    after_pos(); expect_bit("R7", 2, 0); expect_q("R11", 0, 1); sample();
    at_neg(); pl_data = 2'b01;
    after_pos(); expect_bit("R7", 2, 1); sample();

    // R8 combinational option
    at_neg(); cfg_comb = 1; sum_term = 2'b00; #0.3;
    expect_bit("R8", 2, 0); sample();
    sum_term = 2'b01; #0.3;
    expect_bit("R8", 2, 1); sample();

    // R9 tri-stated pin shows external level
    at_neg(); oe_term = 0; cfg_comb = 0; drv_en = 1; drv_val = 0; #0.3;
    expect_bit("R9", 2, 0); expect_bit("R9", 0, 1); sample();
    at_neg(); pl_data = 2'b00; drv_val = 1;
    after_pos(); expect_bit("R9", 2, 1); expect_bit("R9", 0, 0); sample();

    #10;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule